// File: doc/BRIEF.md
# Vectored Multi-Source Interrupt Controller

This block gathers sixteen interrupt sources into one interrupt request for a processor. Eight sources are general-purpose request lines from outside the chip. The other eight are internal events such as timer expiry or serial status. Each source has its own enable, pending, mask and in-service bit. The sixteen bits of each kind are split into an upper byte and a lower byte, and each byte sits at its own register address.

When the processor acknowledges the request, the block returns an 8-bit vector. The low nibble is the number of the winning source. The high nibble is a programmable base, so several instances can share one processor and software can tell them apart. In automatic end-of-interrupt mode, an acknowledge only consumes the pending bit. In software end-of-interrupt mode, it also marks the source as in service. That blocks the source itself and every lower-numbered source until software clears the mark.

All inputs are assumed to be synchronous to `clk`. Register reads are combinational from the address. Writes take effect at the next rising edge.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low and `vec_valid_o` is low.
- R2: Source i is `ext_req[i]` for i in 0..7 and `int_evt[i-8]` for i in 8..15. A rising input edge on an enabled source sets its pending bit at the next clock edge. A held high level does not set it again after it is cleared, and an edge on a disabled source is ignored.
- R3: Writing 0 to an enable bit also clears that source's pending bit in the same edge. Enable bits are at address 0 (sources 15..8) and address 1 (sources 7..0).
- R4: A mask bit of 1 stops its pending source from driving `irq_o` but keeps the pending bit. Writing the mask bit back to 0 restores the request. Mask bits are at address 4 (upper byte) and address 5 (lower byte).
- R5: When `ack_i` is high at a clock edge and `irq_o` is high, `vec_valid_o` is high for the following cycle. During that cycle, `vec_o` holds the base nibble in bits 7:4 and, in bits 3:0, the highest-numbered pending, unmasked and unblocked source.
- R6: An acknowledge clears the pending bit of the source it returns and of no other source.
- R7: Writing 0 to a pending bit clears it, and writing 1 leaves it unchanged. Pending bits are at address 2 (upper byte) and address 3 (lower byte).
- R8: The control register is at address 8. Bits 7:4 are the vector base and bit 0 selects software end-of-interrupt mode. In that mode, an acknowledge sets the in-service bit of the returned source. A set in-service bit blocks requests from its own source and from every lower-numbered source, while higher-numbered sources still raise `irq_o`. In automatic mode, no in-service bit is set.
- R9: In-service bits are at address 6 (upper byte) and address 7 (lower byte). Writing 0 clears a bit and writing 1 leaves it unchanged. Clearing a bit releases the requests it blocked.
- R10: An acknowledge while `irq_o` is low leaves `vec_valid_o` low and changes no pending or in-service bit.
- R11: Address 9 reads the levels of `ext_req` as they were sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req | input | 8 | External request lines, sources 7..0 |
| int_evt | input | 8 | Internal event lines, sources 15..8 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ack_i | input | 1 | Processor acknowledge, one cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_valid_o | output | 1 | `vec_o` is valid this cycle |

## Verification
The bench holds a request line high after software clears its pending bit. A design that detects levels instead of edges would re-pend that source at once. Two sources are left pending together and acknowledged in turn, which catches a priority encoder that picks the lowest number or an acknowledge that clears the wrong bit. In software end-of-interrupt mode, the bench raises a lower source and the very source that is in service, and expects no request. It then clears the in-service bit and expects the request back. A design that compares priority as "greater or equal", or that forgets to release blocked requests, fails there. An acknowledge with nothing pending is also issued; a design that returns a stale vector or sets an in-service bit on it is reported.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants and register addresses for the vectored
// interrupt controller. Assumes 16 sources split over two 8-bit bytes.
package irq_ctrl_pkg;

    localparam int SRC_N  = 16;
    localparam int DW     = 8;
    localparam int ADDR_W = 4;
    localparam int ID_W   = $clog2(SRC_N);
    localparam int BASE_W = DW - ID_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_ENA_HI = 4'd0,
        RA_ENA_LO = 4'd1,
        RA_PND_HI = 4'd2,
        RA_PND_LO = 4'd3,
        RA_MSK_HI = 4'd4,
        RA_MSK_LO = 4'd5,
        RA_ISV_HI = 4'd6,
        RA_ISV_LO = 4'd7,
        RA_CTRL   = 4'd8,
        RA_GPIN   = 4'd9
    } reg_addr_e;

endpackage

// File: rtl/irq_regs.sv
// Module: irq_regs
// Holds the enable, mask and control registers and decodes writes that
// clear pending or in-service bits. Serves combinational reads of all
// registers. Assumes SRC_N == 2*DW: the upper byte covers sources
// SRC_N-1..DW and the lower byte covers DW-1..0.
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int P_SRC_N = SRC_N,
    parameter int P_DW    = DW,
    parameter int P_AW    = ADDR_W,
    parameter int P_BW    = BASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [P_AW-1:0]    addr,
    input  logic [P_DW-1:0]    wdata,
    input  logic [P_SRC_N-1:0] pnd_q,
    input  logic [P_SRC_N-1:0] isv_q,
    input  logic [P_DW-1:0]    gpin,
    output logic [P_DW-1:0]    rdata,
    output logic [P_SRC_N-1:0] ena_q,
    output logic [P_SRC_N-1:0] ena_nxt,
    output logic [P_SRC_N-1:0] msk_q,
    output logic [P_SRC_N-1:0] pnd_wclr,
    output logic [P_SRC_N-1:0] isv_wclr,
    output logic [P_BW-1:0]    vbase_q,
    output logic               sw_eoi_q
);

    localparam int HI = P_SRC_N - 1;
    localparam int LO_TOP = P_DW - 1;
    localparam int PAD_W = P_DW - P_BW - 1;

    logic [P_SRC_N-1:0] msk_nxt;

    // Next value of enable and mask after any write this cycle.
    always_comb begin
        ena_nxt = ena_q;
        msk_nxt = msk_q;
        if (wr_en) begin
            unique case (addr)
                RA_ENA_HI: ena_nxt[HI -: P_DW]     = wdata;
                RA_ENA_LO: ena_nxt[LO_TOP:0]       = wdata;
                RA_MSK_HI: msk_nxt[HI -: P_DW]     = wdata;
                RA_MSK_LO: msk_nxt[LO_TOP:0]       = wdata;
                default: ;
            endcase
        end
    end

    // Write-zero-to-clear strobes for pending and in-service bits.
    always_comb begin
        pnd_wclr = '0;
        isv_wclr = '0;
        if (wr_en) begin
            unique case (addr)
                RA_PND_HI: pnd_wclr[HI -: P_DW] = ~wdata;
                RA_PND_LO: pnd_wclr[LO_TOP:0]   = ~wdata;
                RA_ISV_HI: isv_wclr[HI -: P_DW] = ~wdata;
                RA_ISV_LO: isv_wclr[LO_TOP:0]   = ~wdata;
                default: ;
            endcase
        end
    end

    // Register state update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q    <= '0;
            msk_q    <= '0;
            vbase_q  <= '0;
            sw_eoi_q <= 1'b0;
        end else begin
            ena_q <= ena_nxt;
            msk_q <= msk_nxt;
            if (wr_en && addr == RA_CTRL) begin
                vbase_q  <= wdata[P_DW-1 -: P_BW];
                sw_eoi_q <= wdata[0];
            end
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        unique case (addr)
            RA_ENA_HI: rdata = ena_q[HI -: P_DW];
            RA_ENA_LO: rdata = ena_q[LO_TOP:0];
            RA_PND_HI: rdata = pnd_q[HI -: P_DW];
            RA_PND_LO: rdata = pnd_q[LO_TOP:0];
            RA_MSK_HI: rdata = msk_q[HI -: P_DW];
            RA_MSK_LO: rdata = msk_q[LO_TOP:0];
            RA_ISV_HI: rdata = isv_q[HI -: P_DW];
            RA_ISV_LO: rdata = isv_q[LO_TOP:0];
            RA_CTRL:   rdata = {vbase_q, {PAD_W{1'b0}}, sw_eoi_q};
            RA_GPIN:   rdata = gpin;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_src_latch.sv
// Module: irq_src_latch
// Per-source edge detection plus the pending and in-service flip-flops.
// Assumes src_in is synchronous to clk. A new edge beats a clear in the
// same cycle; a disable (ena_nxt low) beats everything.
module irq_src_latch #(
    parameter int P_SRC_N = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_SRC_N-1:0] src_in,
    input  logic [P_SRC_N-1:0] ena_q,
    input  logic [P_SRC_N-1:0] ena_nxt,
    input  logic [P_SRC_N-1:0] pnd_wclr,
    input  logic [P_SRC_N-1:0] ack_clr,
    input  logic [P_SRC_N-1:0] isv_wclr,
    input  logic [P_SRC_N-1:0] isv_set,
    output logic [P_SRC_N-1:0] prev_q,
    output logic [P_SRC_N-1:0] pnd_q,
    output logic [P_SRC_N-1:0] isv_q
);

    for (genvar g = 0; g < P_SRC_N; g++) begin : g_src
        logic rise;

        // Rising-edge detect against last cycle's sample.
        always_comb rise = src_in[g] & ~prev_q[g];

        // Sample, pending and in-service state of one source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pnd_q[g]  <= 1'b0;
                isv_q[g]  <= 1'b0;
            end else begin
                prev_q[g] <= src_in[g];
                pnd_q[g]  <= ena_nxt[g] &
                             ((pnd_q[g] & ~pnd_wclr[g] & ~ack_clr[g]) |
                              (rise & ena_q[g]));
                isv_q[g]  <= (isv_q[g] & ~isv_wclr[g]) | isv_set[g];
            end
        end
    end

endmodule

// File: rtl/irq_prio_sel.sv
// Module: irq_prio_sel
// Combinational selection: a source is eligible when pending, unmasked
// and above every in-service source. The highest-numbered eligible
// source wins. Assumes a one-hot-free in-service vector is legal.
module irq_prio_sel #(
    parameter int P_SRC_N = 16,
    parameter int P_ID_W  = $clog2(P_SRC_N)
) (
    input  logic [P_SRC_N-1:0] pnd_q,
    input  logic [P_SRC_N-1:0] msk_q,
    input  logic [P_SRC_N-1:0] isv_q,
    output logic               req,
    output logic [P_ID_W-1:0]  win_id
);

    logic [P_SRC_N-1:0] blocked;
    logic [P_SRC_N-1:0] elig;

    // A source is blocked by any in-service bit at or above it.
    always_comb begin
        for (int s = 0; s < P_SRC_N; s++) begin
            blocked[s] = |(isv_q >> s);
        end
    end

    // Eligible sources and the resulting request.
    always_comb begin
        elig = pnd_q & ~msk_q & ~blocked;
        req  = |elig;
    end

    // Highest-numbered eligible source; later hits overwrite earlier.
    always_comb begin
        win_id = '0;
        for (int s = 0; s < P_SRC_N; s++) begin
            if (elig[s]) win_id = P_ID_W'(s);
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: vec_irq_ctrl (top)
// Vectored 16-source interrupt controller. Sources 7..0 are ext_req,
// 15..8 are int_evt. On an acknowledge with a live request, returns
// {base, source} for one cycle and retires the winner's pending bit.
// Assumes ack_i is a single-cycle pulse synchronous to clk.
module vec_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int P_SRC_N = SRC_N,
    parameter int P_DW    = DW,
    parameter int P_AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P_DW-1:0]   ext_req,
    input  logic [P_DW-1:0]   int_evt,
    input  logic              reg_wr,
    input  logic [P_AW-1:0]   reg_addr,
    input  logic [P_DW-1:0]   reg_wdata,
    output logic [P_DW-1:0]   reg_rdata,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [P_DW-1:0]   vec_o,
    output logic              vec_valid_o
);

    localparam int L_ID_W = $clog2(P_SRC_N);
    localparam int L_BW   = P_DW - L_ID_W;

    logic [P_SRC_N-1:0] src_in;
    logic [P_SRC_N-1:0] prev_q;
    logic [P_SRC_N-1:0] pnd_q;
    logic [P_SRC_N-1:0] isv_q;
    logic [P_SRC_N-1:0] ena_q;
    logic [P_SRC_N-1:0] ena_nxt;
    logic [P_SRC_N-1:0] msk_q;
    logic [P_SRC_N-1:0] pnd_wclr;
    logic [P_SRC_N-1:0] isv_wclr;
    logic [P_SRC_N-1:0] ack_clr;
    logic [P_SRC_N-1:0] isv_set;
    logic [L_BW-1:0]    vbase_q;
    logic               sw_eoi_q;
    logic               req;
    logic [L_ID_W-1:0]  win_id;
    logic               ack_take;
    logic [P_DW-1:0]    vec_q;
    logic               vec_vld_q;

    // Source numbering: internal events above external lines.
    always_comb src_in = {int_evt, ext_req};

    irq_regs #(
        .P_SRC_N (P_SRC_N),
        .P_DW    (P_DW),
        .P_AW    (P_AW),
        .P_BW    (L_BW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .pnd_q    (pnd_q),
        .isv_q    (isv_q),
        .gpin     (prev_q[P_DW-1:0]),
        .rdata    (reg_rdata),
        .ena_q    (ena_q),
        .ena_nxt  (ena_nxt),
        .msk_q    (msk_q),
        .pnd_wclr (pnd_wclr),
        .isv_wclr (isv_wclr),
        .vbase_q  (vbase_q),
        .sw_eoi_q (sw_eoi_q)
    );

    irq_src_latch #(
        .P_SRC_N (P_SRC_N)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .ena_q    (ena_q),
        .ena_nxt  (ena_nxt),
        .pnd_wclr (pnd_wclr),
        .ack_clr  (ack_clr),
        .isv_wclr (isv_wclr),
        .isv_set  (isv_set),
        .prev_q   (prev_q),
        .pnd_q    (pnd_q),
        .isv_q    (isv_q)
    );

    irq_prio_sel #(
        .P_SRC_N (P_SRC_N),
        .P_ID_W  (L_ID_W)
    ) u_prio (
        .pnd_q  (pnd_q),
        .msk_q  (msk_q),
        .isv_q  (isv_q),
        .req    (req),
        .win_id (win_id)
    );

    // Acknowledge decode: retire the winner, mark it in service if asked.
    always_comb begin
        ack_take = ack_i & req;
        ack_clr  = ack_take ? (P_SRC_N'(1) << win_id) : '0;
        isv_set  = (ack_take && sw_eoi_q) ? ack_clr : '0;
    end

    // Vector register and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q     <= '0;
            vec_vld_q <= 1'b0;
        end else begin
            vec_vld_q <= ack_take;
            if (ack_take) vec_q <= {vbase_q, win_id};
        end
    end

    // Output drive.
    always_comb begin
        irq_o       = req;
        vec_o       = vec_q;
        vec_valid_o = vec_vld_q;
    end

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
// Module: vec_irq_ctrl_chk
// Assertion checker bound to vec_irq_ctrl; observes ports and the
// state registers that separate sub-blocks drive.
module vec_irq_ctrl_chk #(
    parameter int P_SRC_N = 16,
    parameter int P_DW    = 8,
    parameter int P_ID_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_i,
    input logic               irq_o,
    input logic               vec_valid_o,
    input logic [P_DW-1:0]    vec_o,
    input logic [P_SRC_N-1:0] pnd_q,
    input logic [P_SRC_N-1:0] msk_q,
    input logic [P_SRC_N-1:0] isv_q,
    input logic [P_SRC_N-1:0] ena_q
);

    // R5: a vector is only offered right after an accepted acknowledge.
    a_r5_vec_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> ($past(ack_i) && $past(irq_o)));

    // R10: an acknowledge with no request yields no vector.
    a_r10_idle_ack_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o) |=> !vec_valid_o);

    // R3: no source is pending while disabled.
    a_r3_pnd_within_ena: assert property (@(posedge clk) disable iff (!rst_n)
        (pnd_q & ~ena_q) == '0);

    // R4: the request needs at least one unmasked pending source.
    a_r4_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pnd_q & ~msk_q) != '0));

    // R8: a returned source lies above every in-service source.
    a_r8_vec_above_isv: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (($past(isv_q) >> vec_o[P_ID_W-1:0]) == '0));

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
    .P_SRC_N (P_SRC_N),
    .P_DW    (P_DW),
    .P_ID_W  (L_ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .irq_o       (irq_o),
    .vec_valid_o (vec_valid_o),
    .vec_o       (vec_o),
    .pnd_q       (pnd_q),
    .msk_q       (msk_q),
    .isv_q       (isv_q),
    .ena_q       (ena_q)
);

// File: tb/vec_irq_ctrl_tb.sv
// Directed bench for vec_irq_ctrl: one task per scenario.
module vec_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ext_req = '0;
    logic [7:0] int_evt = '0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ack_i = 1'b0;
    logic       irq_o;
    logic [7:0] vec_o;
    logic       vec_valid_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_req     (ext_req),
        .int_evt     (int_evt),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ack_i       (ack_i),
        .irq_o       (irq_o),
        .vec_o       (vec_o),
        .vec_valid_o (vec_valid_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input int exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_ext(input int i);
        @(negedge clk); ext_req[i] = 1'b1;
        @(negedge clk); ext_req[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_evt(input int i);
        @(negedge clk); int_evt[i] = 1'b1;
        @(negedge clk); int_evt[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_ack(input string tag, input int exp_vld, input int exp_vec);
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk);
        chk({tag, " valid"}, vec_valid_o, exp_vld);
        if (exp_vld != 0) chk({tag, " vector"}, vec_o, exp_vec);
        ack_i = 1'b0;
        @(negedge clk);
        chk({tag, " valid drops"}, vec_valid_o, 0);
    endtask

    // R1: reset values.
    task automatic t_reset();
        for (int a = 0; a < 10; a++) rd_chk("R1 reg reset", 4'(a), 0);
        chk("R1 irq reset", irq_o, 0);
        chk("R1 valid reset", vec_valid_o, 0);
    endtask

    // R11: input sample register.
    task automatic t_gpin();
        @(negedge clk); ext_req = 8'hA5;
        @(negedge clk);
        rd_chk("R11 gpin", 4'd9, 8'hA5);
        ext_req = 8'h00;
        @(negedge clk);
    endtask

    // R2 and R7: edge latching and write-zero-to-clear.
    task automatic t_latch();
        wr(4'd1, 8'h04);
        pulse_ext(2);
        rd_chk("R2 edge pends", 4'd3, 8'h04);
        chk("R2 irq up", irq_o, 1);
        pulse_ext(3);
        rd_chk("R2 disabled ignored", 4'd3, 8'h04);
        wr(4'd3, 8'hFF);
        rd_chk("R7 write one keeps", 4'd3, 8'h04);
        @(negedge clk); ext_req[2] = 1'b1;
        wr(4'd3, 8'hFB);
        repeat (3) @(negedge clk);
        rd_chk("R2 level no repend", 4'd3, 8'h00);
        chk("R7 irq after clear", irq_o, 0);
        ext_req[2] = 1'b0;
        @(negedge clk);
    endtask

    // R3: disabling clears pending.
    task automatic t_ena_clr();
        pulse_ext(2);
        rd_chk("R3 pend before", 4'd3, 8'h04);
        wr(4'd1, 8'h00);
        rd_chk("R3 pend gone", 4'd3, 8'h00);
        chk("R3 irq gone", irq_o, 0);
    endtask

    // R4: masking holds pending but drops the request.
    task automatic t_mask();
        wr(4'd0, 8'h02);
        pulse_evt(1);
        wr(4'd4, 8'h02);
        chk("R4 masked irq", irq_o, 0);
        rd_chk("R4 pend kept", 4'd2, 8'h02);
        wr(4'd4, 8'h00);
        chk("R4 unmasked irq", irq_o, 1);
    endtask

    // R5, R6, R10: priority order and acknowledge.
    task automatic t_prio();
        wr(4'd8, 8'h30);
        wr(4'd1, 8'h10);
        pulse_ext(4);
        do_ack("R5 first is 9", 1, 8'h39);
        rd_chk("R6 hi cleared", 4'd2, 8'h00);
        rd_chk("R6 lo kept", 4'd3, 8'h10);
        do_ack("R5 second is 4", 1, 8'h34);
        rd_chk("R8 auto no isv", 4'd7, 8'h00);
        do_ack("R10 idle ack", 0, 0);
        rd_chk("R10 no isv", 4'd7, 8'h00);
    endtask

    // R8 and R9: in-service nesting in software mode.
    task automatic t_eoi();
        wr(4'd8, 8'h31);
        wr(4'd1, 8'h14);
        pulse_ext(4);
        do_ack("R8 take 4", 1, 8'h34);
        rd_chk("R8 isv set", 4'd7, 8'h10);
        pulse_ext(2);
        rd_chk("R8 low pends", 4'd3, 8'h04);
        chk("R8 low blocked", irq_o, 0);
        pulse_ext(4);
        chk("R8 same blocked", irq_o, 0);
        pulse_evt(1);
        chk("R8 higher passes", irq_o, 1);
        do_ack("R8 nest 9", 1, 8'h39);
        rd_chk("R8 isv hi", 4'd6, 8'h02);
        wr(4'd6, 8'hFD);
        rd_chk("R9 isv hi cleared", 4'd6, 8'h00);
        chk("R9 still blocked", irq_o, 0);
        wr(4'd7, 8'hEF);
        chk("R9 released", irq_o, 1);
        do_ack("R9 take 4 again", 1, 8'h34);
        chk("R8 2 blocked again", irq_o, 0);
        wr(4'd7, 8'hEF);
        do_ack("R9 take 2", 1, 8'h32);
        rd_chk("R8 isv lo 2", 4'd7, 8'h04);
        wr(4'd7, 8'hFB);
        rd_chk("R9 isv lo clear", 4'd7, 8'h00);
    endtask

    initial begin
        #4ms;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gpin();
        t_latch();
        t_ena_clr();
        t_mask();
        t_prio();
        t_eoi();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule